// File: doc/BRIEF.md
# Zone Bus Cycle Sequencer

This block turns requests from one on-chip master into timed bus cycles on a single external memory or I/O zone. The zone is a 256-byte window picked out by the upper address bits. Requests that fall outside the window are left alone, so other logic can serve them. Two small configuration registers set the cycle shape:

- **Timing register:** selects early or late write strobes.
- **Zone register:** sets the wait-state count, the hold-state count, the bus width and whether one idle clock is added before the bus is released.

A byte cycle runs through the following states in order:

1. An address clock.
2. 0 to 7 wait clocks.
3. A data clock.
4. One extra write clock, for late writes only.
5. 0 to 3 hold clocks.

When the zone is 8 bits wide, a master access with both byte lanes enabled runs as two byte cycles, low byte first. The master holds its request until it sees a one-clock ready pulse. On a read, the returned data is valid in the same clock as that pulse. The block drives a busy flag while it owns the zone bus. Other zones' logic waits for that flag to fall.

Top module: `zbus_seq`

## Requirements
- R1: After reset the timing register reads 0007h. The zone register reads 069Fh. That value means wait 7 in bits 2:0, hold 3 in bits 4:3, 16-bit width in bit 7, and post-idle off in bit 8. Ready, busy and both strobes are low after reset.
- R2: The timing register keeps only bit 0, where 1 means early write. Its bits 2:1 always read 1 and its other bits read 0. The zone register keeps bits 2:0, 4:3, 7 and 8. Its bits 10:9 always read 1 and its other bits read 0. Writes to the fixed bits have no effect.
- R3: A read byte cycle lasts 2 + W + H clocks, where W is the wait field and H is the hold field. Clocks are counted from the first clock edge that sees an in-window request to the clock in which ready is high.
- R4: An early-write byte cycle lasts 2 + W + H clocks. A late-write byte cycle lasts 3 + W + H clocks.
- R5: Ready is high for exactly one clock per transfer. Read data on the master side is valid in that clock.
- R6: On an 8-bit zone (bit 7 = 0), a master access with byte enables 11 runs as two byte cycles. The first cycle uses the even address and the second uses the odd address. Each cycle applies the full W and H. The total length is twice the byte-cycle length.
- R7: On a 16-bit zone, an access runs as one cycle at the even address. The zone byte enables equal the master byte enables.
- R8: On an 8-bit zone, an access with byte enables 01 or 10 runs one byte cycle. That cycle uses the even or odd address respectively and carries the byte on zone data bits 7:0. A read returns the byte in the matching master lane.
- R9: A request whose upper address bits do not match the window produces no strobe, no ready and no busy.
- R10: With post-idle set, busy stays high for one clock after the ready clock when no in-window request follows. A following in-window request starts with no added clock. With post-idle clear, busy falls in the clock after ready.
- R11: The read strobe is high for 2 + W clocks per byte cycle, starting in the address clock. The early write strobe is high for 2 + W clocks starting in the address clock. The late write strobe is low in the address clock and high for the next 2 + W clocks. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the timing register, 1 the zone register |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Readback of the selected register |
| m_req | input | 1 | Master request, held until ready |
| m_addr | input | ADDR_W | Master byte address (bit 0 ignored) |
| m_we | input | 1 | 1 for write, 0 for read |
| m_be | input | 2 | Master byte enables, bit 0 = low lane |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Read data, valid with ready |
| m_rdy | output | 1 | One-clock transfer completion |
| zone_busy | output | 1 | Block owns the zone bus |
| z_addr | output | WIN_W | Byte offset within the zone window |
| z_be | output | 2 | Zone byte enables |
| z_wdata | output | 16 | Zone write data |
| z_rdata | input | 16 | Zone read data |
| z_rd | output | 1 | Zone read strobe |
| z_wr | output | 1 | Zone write strobe |

## Verification
The bench builds the block with its defaults: a 24-bit address, an 8-bit window offset and the window at FFFB00h. These values bring the whole 256-byte window within reach, along with the neighbouring addresses just below and just above it. The bench sweeps all 8 wait values, all 4 hold values and both bus widths. The top of the window at offset FEh and the two adjacent out-of-window addresses are then tried directly.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
  localparam int DW     = 16;
  localparam int BYTE_W = 8;
  localparam int WAIT_W = 3;
  localparam int HOLD_W = 2;
  localparam int CNT_W  = WAIT_W;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_LATE = 3'd4,
    ST_HOLD = 3'd5,
    ST_GAP  = 3'd6
  } zstate_t;

  typedef struct packed {
    logic              early_wr;
    logic              post_idle;
    logic              wide;
    logic [HOLD_W-1:0] hold_n;
    logic [WAIT_W-1:0] wait_n;
  } zcfg_t;
endpackage

// File: rtl/zbus_cfg.sv
module zbus_cfg
  import zbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output zcfg_t         cfg
);
  localparam int HOLD_LSB = WAIT_W;
  localparam int WIDE_BIT = 7;
  localparam int IDLE_BIT = 8;

  zcfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.early_wr  <= 1'b1;
      cfg_q.post_idle <= 1'b0;
      cfg_q.wide      <= 1'b1;
      cfg_q.hold_n    <= '1;
      cfg_q.wait_n    <= '1;
    end else if (wr) begin
      if (!sel) begin
        cfg_q.early_wr <= wdata[0];
      end else begin
        cfg_q.wait_n    <= wdata[WAIT_W-1:0];
        cfg_q.hold_n    <= wdata[HOLD_LSB+HOLD_W-1:HOLD_LSB];
        cfg_q.wide      <= wdata[WIDE_BIT];
        cfg_q.post_idle <= wdata[IDLE_BIT];
      end
    end
  end

  always_comb begin
    if (sel) rdata = {5'b0, 2'b11, cfg_q.post_idle, cfg_q.wide, 2'b00, cfg_q.hold_n, cfg_q.wait_n};
    else     rdata = {13'b0, 2'b11, cfg_q.early_wr};
  end

  assign cfg = cfg_q;

  assert_tim_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && !sel) |=> (cfg_q.early_wr == $past(wdata[0])));
  assert_zone_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && sel) |=> (cfg_q.wide == $past(wdata[WIDE_BIT])) && (cfg_q.post_idle == $past(wdata[IDLE_BIT])));
endmodule

// File: rtl/zbus_win.sv
module zbus_win #(
  parameter int          ADDR_W    = 24,
  parameter int          WIN_W     = 8,
  parameter logic [ADDR_W-1:0] ZONE_BASE = 24'hFFFB00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [WIN_W-2:0]  word_off
);
  localparam int TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0] TAG = ZONE_BASE[ADDR_W-1:WIN_W];

  assign hit      = (addr[ADDR_W-1:WIN_W] == TAG);
  assign word_off = addr[WIN_W-1:1];
endmodule

// File: rtl/zbus_lane.sv
module zbus_lane
  import zbus_pkg::*;
(
  input  logic          wide,
  input  logic          lane,
  input  logic [DW-1:0] wd_q,
  input  logic [DW-1:0] rd_q,
  input  logic [DW-1:0] z_rdata,
  output logic [DW-1:0] z_wdata,
  output logic [DW-1:0] rd_next
);
  localparam int HI = DW - 1;
  localparam int LO = BYTE_W - 1;

  always_comb begin
    if (wide) begin
      z_wdata = wd_q;
      rd_next = z_rdata;
    end else if (lane) begin
      z_wdata = {{BYTE_W{1'b0}}, wd_q[HI:BYTE_W]};
      rd_next = {z_rdata[LO:0], rd_q[LO:0]};
    end else begin
      z_wdata = {{BYTE_W{1'b0}}, wd_q[LO:0]};
      rd_next = {rd_q[HI:BYTE_W], z_rdata[LO:0]};
    end
  end
endmodule

// File: rtl/zbus_fsm.sv
module zbus_fsm
  import zbus_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  zcfg_t            cfg,
  input  logic             m_req,
  input  logic             hit,
  input  logic [WIN_W-2:0] word_off,
  input  logic             m_we,
  input  logic [1:0]       m_be,
  input  logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    rd_next,
  output logic             lane,
  output logic [DW-1:0]    wd_q,
  output logic [DW-1:0]    rd_q,
  output logic [WIN_W-1:0] z_addr,
  output logic [1:0]       z_be,
  output logic             z_rd,
  output logic             z_wr,
  output logic             m_rdy,
  output logic [DW-1:0]    m_rdata,
  output logic             busy
);
  zstate_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-2:0] off_q;
  logic             we_q, split_q, lane_q, lane_d;
  logic [1:0]       be_q;
  logic             start, data_end, byte_end, last_byte, is_late;
  logic [CNT_W-1:0] hold_ext;

  assign hold_ext  = {{(CNT_W-HOLD_W){1'b0}}, cfg.hold_n};
  assign is_late   = we_q && !cfg.early_wr;
  assign last_byte = !(split_q && !lane_q);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    lane_d   = lane_q;
    start    = 1'b0;
    data_end = 1'b0;
    byte_end = 1'b0;
    case (st_q)
      ST_IDLE, ST_GAP: begin
        if (m_req && hit) begin
          start = 1'b1;
          st_d  = ST_ADDR;
        end else begin
          st_d  = ST_IDLE;
        end
      end
      ST_ADDR: begin
        if (cfg.wait_n != '0) begin
          st_d  = ST_WAIT;
          cnt_d = CNT_W'(1);
        end else begin
          st_d  = ST_DATA;
        end
      end
      ST_WAIT: begin
        if (cnt_q >= cfg.wait_n) st_d = ST_DATA;
        else cnt_d = cnt_q + CNT_W'(1);
      end
      ST_DATA: begin
        if (is_late) st_d = ST_LATE;
        else data_end = 1'b1;
      end
      ST_LATE: data_end = 1'b1;
      ST_HOLD: begin
        if (cnt_q >= hold_ext) byte_end = 1'b1;
        else cnt_d = cnt_q + CNT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (data_end) begin
      if (cfg.hold_n != '0) begin
        st_d  = ST_HOLD;
        cnt_d = CNT_W'(1);
      end else begin
        byte_end = 1'b1;
      end
    end
    if (byte_end) begin
      if (!last_byte) begin
        st_d   = ST_ADDR;
        lane_d = 1'b1;
      end else begin
        st_d   = cfg.post_idle ? ST_GAP : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= 2'b00;
      wd_q    <= '0;
      split_q <= 1'b0;
      lane_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start) begin
        off_q   <= word_off;
        we_q    <= m_we;
        be_q    <= m_be;
        wd_q    <= m_wdata;
        split_q <= !cfg.wide && (m_be == 2'b11);
        lane_q  <= !cfg.wide && (m_be == 2'b10);
      end else begin
        lane_q  <= lane_d;
      end
      if (st_q == ST_DATA && !we_q) rd_q <= rd_next;
    end
  end

  assign lane    = lane_q;
  assign m_rdy   = byte_end && last_byte;
  assign m_rdata = (st_q == ST_DATA) ? rd_next : rd_q;
  assign busy    = (st_q != ST_IDLE);
  assign z_addr  = cfg.wide ? {off_q, 1'b0} : {off_q, lane_q};
  assign z_be    = cfg.wide ? be_q : 2'b01;
  assign z_rd    = !we_q && (st_q == ST_ADDR || st_q == ST_WAIT || st_q == ST_DATA);
  assign z_wr    = we_q && (cfg.early_wr ? (st_q == ST_ADDR || st_q == ST_WAIT || st_q == ST_DATA)
                                         : (st_q == ST_WAIT || st_q == ST_DATA || st_q == ST_LATE));

  assert_rdy_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    m_rdy |=> !m_rdy);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(z_rd && z_wr));
  assert_miss_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && m_req && !hit) |=> (st_q == ST_IDLE));
  assert_gap_after_rdy_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GAP) |-> $past(m_rdy));
  assert_split_second_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR && $past(st_q) != ST_IDLE && $past(st_q) != ST_GAP) |-> lane_q);
  assert_late_first_low_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR && is_late) |-> !z_wr);
endmodule

// File: rtl/zbus_seq.sv
module zbus_seq
  import zbus_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          WIN_W     = 8,
  parameter logic [ADDR_W-1:0] ZONE_BASE = 24'hFFFB00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              m_req,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              m_we,
  input  logic [1:0]        m_be,
  input  logic [15:0]       m_wdata,
  output logic [15:0]       m_rdata,
  output logic              m_rdy,
  output logic              zone_busy,
  output logic [WIN_W-1:0]  z_addr,
  output logic [1:0]        z_be,
  output logic [15:0]       z_wdata,
  input  logic [15:0]       z_rdata,
  output logic              z_rd,
  output logic              z_wr
);
  zcfg_t            cfg;
  logic             hit, lane;
  logic [WIN_W-2:0] word_off;
  logic [DW-1:0]    wd_q, rd_q, rd_next;

  zbus_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  zbus_win #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .ZONE_BASE(ZONE_BASE)) u_win (
    .addr(m_addr), .hit(hit), .word_off(word_off)
  );

  zbus_lane u_lane (
    .wide(cfg.wide), .lane(lane), .wd_q(wd_q), .rd_q(rd_q),
    .z_rdata(z_rdata), .z_wdata(z_wdata), .rd_next(rd_next)
  );

  zbus_fsm #(.WIN_W(WIN_W)) u_fsm (
    .clk(clk), .rst(rst), .cfg(cfg), .m_req(m_req), .hit(hit),
    .word_off(word_off), .m_we(m_we), .m_be(m_be), .m_wdata(m_wdata),
    .rd_next(rd_next), .lane(lane), .wd_q(wd_q), .rd_q(rd_q),
    .z_addr(z_addr), .z_be(z_be), .z_rd(z_rd), .z_wr(z_wr),
    .m_rdy(m_rdy), .m_rdata(m_rdata), .busy(zone_busy)
  );
endmodule

// File: tb/zbus_seq_tb.sv
module zbus_seq_tb;
  localparam logic [23:0] BASE = 24'hFFFB00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic m_req = 0, m_we = 0;
  logic [23:0] m_addr = '0;
  logic [1:0] m_be = 2'b11;
  logic [15:0] m_wdata = '0, m_rdata;
  logic m_rdy, zone_busy, z_rd, z_wr;
  logic [7:0] z_addr;
  logic [1:0] z_be;
  logic [15:0] z_wdata, z_rdata;
  logic cur_bw = 1'b1;
  logic [7:0] mem [256];
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zbus_seq u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_be(m_be),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_rdy(m_rdy), .zone_busy(zone_busy),
    .z_addr(z_addr), .z_be(z_be), .z_wdata(z_wdata), .z_rdata(z_rdata),
    .z_rd(z_rd), .z_wr(z_wr)
  );

  // zone memory model
  assign z_rdata = cur_bw ? {mem[{z_addr[7:1], 1'b1}], mem[{z_addr[7:1], 1'b0}]}
                          : {8'h00, mem[z_addr]};
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (z_wr) begin
      if (cur_bw) begin
        if (z_be[0]) mem[{z_addr[7:1], 1'b0}] <= z_wdata[7:0];
        if (z_be[1]) mem[{z_addr[7:1], 1'b1}] <= z_wdata[15:8];
      end else begin
        mem[z_addr] <= z_wdata[7:0];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic sel, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic set_cfg(input logic bw, input logic ew, input int w, input int h, input logic pi);
    cfg_write(1'b0, {15'b0, ew});
    cfg_write(1'b1, {7'b0, pi, bw, 2'b00, 2'(h), 3'(w)});
    cur_bw = bw;
  endtask

  // one transfer; counts clocks from request to ready
  task automatic xfer(input logic [23:0] a, input logic we, input logic [1:0] be,
                      input logic [15:0] wd, output int cyc, output int strb,
                      output logic first_st, output logic [7:0] fa, output logic [7:0] la,
                      output logic [15:0] rd, output logic rdy_after, output logic busy_after);
    cyc = 0; strb = 0; first_st = 0; fa = 0; la = 0; rd = 0;
    rdy_after = 0; busy_after = 0;
    m_req = 1; m_addr = a; m_we = we; m_be = be; m_wdata = wd;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (z_rd || z_wr) begin
        if (strb == 0) fa = z_addr;
        la = z_addr;
        strb++;
      end
      if (cyc == 1) first_st = z_rd || z_wr;
      if (m_rdy) begin
        rd = m_rdata;
        m_req = 0;
        break;
      end
      if (cyc > 100) begin
        m_req = 0;
        break;
      end
    end
    @(posedge clk);
    @(negedge clk);
    rdy_after  = m_rdy;
    busy_after = zone_busy;
  endtask

  // vector: bw, ew, we, wait, hold, be, offset, expected cycles
  localparam logic [23:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 2'b11, 8'h10, 6'd2},
    {1'b1, 1'b1, 1'b1, 3'd0, 2'd0, 2'b11, 8'h20, 6'd2},
    {1'b1, 1'b0, 1'b1, 3'd0, 2'd0, 2'b11, 8'h22, 6'd3},
    {1'b0, 1'b1, 1'b0, 3'd2, 2'd1, 2'b11, 8'h30, 6'd10},
    {1'b0, 1'b0, 1'b1, 3'd1, 2'd2, 2'b11, 8'h40, 6'd12},
    {1'b0, 1'b1, 1'b0, 3'd3, 2'd0, 2'b10, 8'h51, 6'd5},
    {1'b1, 1'b1, 1'b0, 3'd7, 2'd3, 2'b01, 8'hFE, 6'd12},
    {1'b0, 1'b0, 1'b1, 3'd0, 2'd0, 2'b01, 8'h60, 6'd3}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    int cyc, strb, nb, bw, h;
    logic fs, ra, ba;
    logic [7:0] fa, la, off0, off1;
    logic [15:0] rd, d, exp, msk, wd;
    logic [5:0] ecyc;
    logic ew, we;
    logic [2:0] w;
    logic [1:0] be;
    logic [7:0] off;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    cfg_read(1'b0, d); chk("R1 timing reset", d, 16'h0007);
    cfg_read(1'b1, d); chk("R1 zone reset", d, 16'h069F);
    chk("R1 outputs idle", {m_rdy, zone_busy, z_rd, z_wr}, 4'b0);

    // R2 fixed and reserved bits
    cfg_write(1'b0, 16'h0000); cfg_read(1'b0, d); chk("R2 timing zero", d, 16'h0006);
    cfg_write(1'b0, 16'hFFFF); cfg_read(1'b0, d); chk("R2 timing ones", d, 16'h0007);
    cfg_write(1'b1, 16'hFFFF); cfg_read(1'b1, d); chk("R2 zone ones", d, 16'h079F);
    cfg_write(1'b1, 16'h0000); cfg_read(1'b1, d); chk("R2 zone zero", d, 16'h0600);

    // vector table
    for (int i = 0; i < 8; i++) begin
      {bw[0], ew, we, w, h[1:0], be, off, ecyc} = VEC[i];
      bw = int'(bw[0]); h = int'(h[1:0]);
      set_cfg(bw[0], ew, int'(w), h, 1'b0);
      wd = {8'hC0 + 8'(i), 8'h30 + 8'(i)};
      off0 = {off[7:1], 1'b0}; off1 = {off[7:1], 1'b1};
      exp = {mem[off1], mem[off0]};
      xfer(BASE | 24'(off), we, be, wd, cyc, strb, fs, fa, la, rd, ra, ba);
      nb = (bw == 0 && be == 2'b11) ? 2 : 1;
      chk(we ? "R4 write length" : "R3 read length", 32'(cyc), 32'(ecyc));
      chk("R5 ready single clock", {31'b0, ra}, 0);
      chk("R11 strobe clocks", 32'(strb), 32'(nb * (2 + int'(w))));
      chk("R11 first clock strobe", {31'b0, fs}, {31'b0, !(we && !ew)});
      if (bw == 1) begin
        chk("R7 wide address", {fa, la}, {off0, off0});
      end else if (be == 2'b11) begin
        chk("R6 split order", {fa, la}, {off0, off1});
      end else begin
        chk("R8 single byte address", {fa, la}, be[1] ? {off1, off1} : {off0, off0});
      end
      msk = {{8{be[1]}}, {8{be[0]}}};
      if (!we) begin
        chk(bw == 1 ? "R7 read data" : "R8 read data", rd & msk, exp & msk);
      end else begin
        chk(bw == 1 ? "R7 write data" : "R6 write data", {mem[off1], mem[off0]},
            (wd & msk) | (exp & ~msk));
      end
    end

    // sweep every wait, hold and width
    for (int b = 0; b < 2; b++) begin
      for (int wi = 0; wi < 8; wi++) begin
        for (int hi = 0; hi < 4; hi++) begin
          set_cfg(b[0], 1'b1, wi, hi, 1'b0);
          exp = {mem[8'h81], mem[8'h80]};
          xfer(BASE | 24'h80, 1'b0, 2'b11, 16'h0, cyc, strb, fs, fa, la, rd, ra, ba);
          chk(b == 0 ? "R6 split length" : "R3 read length", 32'(cyc),
              32'((b == 0 ? 2 : 1) * (2 + wi + hi)));
          chk(b == 0 ? "R6 split data" : "R5 read data", rd, exp);
        end
      end
    end

    // R10 post-idle
    set_cfg(1'b1, 1'b1, 0, 0, 1'b1);
    xfer(BASE | 24'h02, 1'b0, 2'b11, 16'h0, cyc, strb, fs, fa, la, rd, ra, ba);
    chk("R10 busy in idle clock", {31'b0, ba}, 1);
    @(negedge clk);
    chk("R10 busy released", {31'b0, zone_busy}, 0);
    xfer(BASE | 24'h04, 1'b0, 2'b11, 16'h0, cyc, strb, fs, fa, la, rd, ra, ba);
    xfer(BASE | 24'h06, 1'b0, 2'b11, 16'h0, cyc, strb, fs, fa, la, rd, ra, ba);
    chk("R10 back to back no added clock", 32'(cyc), 2);
    @(negedge clk);
    set_cfg(1'b1, 1'b1, 0, 0, 1'b0);
    xfer(BASE | 24'h08, 1'b0, 2'b11, 16'h0, cyc, strb, fs, fa, la, rd, ra, ba);
    chk("R10 no idle when clear", {31'b0, ba}, 0);

    // R9 outside the window, both neighbours
    for (int k = 0; k < 2; k++) begin
      int hits;
      hits = 0;
      @(negedge clk);
      m_req = 1; m_we = 0; m_be = 2'b11;
      m_addr = (k == 0) ? BASE - 24'd1 : BASE + 24'd256;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (m_rdy || z_rd || z_wr || zone_busy) hits++;
      end
      m_req = 0;
      chk("R9 outside window ignored", 32'(hits), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule